// File: doc/BRIEF.md
# Keypad Status and Control Register

This block turns ten active-high button lines into a 16-bit active-low status word, read one byte at a time over a small register port. Before the direction buttons are shown, the block removes combinations that a real direction pad cannot produce. If up and down are both pressed, neither is reported. The same applies to left and right. The button lines are asynchronous to the register clock, so they pass through a synchronizer first.

The same port also holds a 16-bit key control word. Software can read it and write its two bytes independently. The block stores this word and does nothing else with it. The register port is combinational on reads and takes writes on the rising clock edge.

Byte offsets on `addr_i`:

| Offset | Contents |
|--------|----------|
| 0 | Status low byte |
| 1 | Status high byte |
| 2 | Control low byte |
| 3 | Control high byte |

Top module: `keypad_status_reg`

## Requirements
- R1: While `rst_n` is low, and at the first read after reset with no button pressed, the port reads as follows: offset 0 reads 0xFF, offset 1 reads 0x03, and offsets 2 and 3 read 0x00.
- R2: Button n, for n from 0 to 7, drives status bit n at offset 0. The bit is active-low: it reads 0 when the button is pressed and 1 when it is released.
- R3: Buttons 8 and 9 appear inverted in bits [1:0] of offset 1. Bits [7:2] of offset 1 always read 0.
- R4: When buttons 6 and 7 (up and down) are both pressed, offset 0 bits [7:6] both read 1. The other bits are not affected.
- R5: When buttons 4 and 5 (right and left) are both pressed, offset 0 bits [5:4] both read 1. The other bits are not affected.
- R6: A write to offset 2 loads `wdata_i` into control bits [7:0] and leaves bits [15:8] unchanged.
- R7: A write to offset 3 loads `wdata_i` into control bits [15:8] and leaves bits [7:0] unchanged.
- R8: Writes to offsets 0 and 1 are ignored. They change neither the status nor the control word.
- R9: A change on `btn_i` that is set up before a rising edge appears on the status read after exactly two rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_i | input | 10 | Button lines, 1 = pressed |
| addr_i | input | 2 | Byte offset for read and write |
| wr_en_i | input | 1 | Write strobe for the offset on `addr_i` |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data byte for the offset on `addr_i` |

## Verification
The assertions assume that `addr_i`, `wr_en_i` and `wdata_i` hold known values at every rising edge outside reset. They also assume that a write applies to exactly the offset shown on `addr_i` in that cycle. The bench changes every input half a period away from the rising edge, so each edge sees a settled offset and strobe. It never leaves the button lines undriven. Pressed combinations include both opposing pairs at once, so the pair-filter properties are exercised together with unrelated buttons.

// File: rtl/keypad_status_reg.sv
module keypad_status_reg #(
  parameter int BTN_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BTN_W-1:0] btn_i,
  input  logic [1:0]       addr_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o
);

  localparam int HI_W = BTN_W - 8;

  logic [BTN_W-1:0] sync_q [SYNC_STAGES];
  logic [BTN_W-1:0] held;
  logic [BTN_W-1:0] pressed;
  logic [15:0]      status;
  logic [15:0]      ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= btn_i;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  assign held = sync_q[SYNC_STAGES-1];

  always_comb begin
    pressed = held;
    if (held[7] && held[6]) pressed[7:6] = 2'b00;
    if (held[5] && held[4]) pressed[5:4] = 2'b00;
  end

  assign status = {{(8-HI_W){1'b0}}, ~pressed[BTN_W-1:8], ~pressed[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == 2'd2) ctrl_q[7:0]  <= wdata_i;
      if (addr_i == 2'd3) ctrl_q[15:8] <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      2'd0:    rdata_o = status[7:0];
      2'd1:    rdata_o = status[15:8];
      2'd2:    rdata_o = ctrl_q[7:0];
      default: rdata_o = ctrl_q[15:8];
    endcase
  end

endmodule

module keypad_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  addr_i,
  input logic        wr_en_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  rdata_o,
  input logic [15:0] ctrl_q
);

  AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    addr_i == 2'd1 |-> rdata_o[7:2] == 6'd0); // R3

  AST_NO_UP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    addr_i == 2'd0 |-> rdata_o[7:6] != 2'b00); // R4

  AST_NO_LEFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    addr_i == 2'd0 |-> rdata_o[5:4] != 2'b00); // R5

  AST_CTRL_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && addr_i == 2'd2 |=> ctrl_q[7:0] == $past(wdata_i) && $stable(ctrl_q[15:8])); // R6

  AST_CTRL_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && addr_i == 2'd3 |=> ctrl_q[15:8] == $past(wdata_i) && $stable(ctrl_q[7:0])); // R7

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !addr_i[1] |=> $stable(ctrl_q)); // R8

endmodule

bind keypad_status_reg keypad_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .ctrl_q(ctrl_q)
);

// File: tb/keypad_status_reg_test.sv
module keypad_status_reg_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [9:0] btn = '0;
  logic [1:0] addr = '0;
  logic       we = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int hist[$];
  int m_ctrl = 0;

  keypad_status_reg uut (
    .clk(clk), .rst_n(rst_n), .btn_i(btn), .addr_i(addr),
    .wr_en_i(we), .wdata_i(wdata), .rdata_o(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {};
      m_ctrl = 0;
    end else begin
      hist.push_front(int'(btn));
      if (hist.size() > 2) void'(hist.pop_back());
      if (we && addr == 2) m_ctrl = (m_ctrl & 32'hFF00) | int'(wdata);
      if (we && addr == 3) m_ctrl = (m_ctrl & 32'h00FF) | (int'(wdata) << 8);
    end
  end

  function automatic int expected(int a);
    int b;
    int p;
    b = (hist.size() >= 2) ? hist[1] : 0;
    p = b;
    if (((b >> 6) & 3) == 3) p = p & ~32'hC0;
    if (((b >> 4) & 3) == 3) p = p & ~32'h30;
    case (a)
      0: return (~p) & 32'hFF;
      1: return (~(p >> 8)) & 32'h03;
      2: return m_ctrl & 32'hFF;
      default: return (m_ctrl >> 8) & 32'hFF;
    endcase
  endfunction

  task automatic step(input logic [9:0] b, input logic [1:0] a, input logic w,
                      input logic [7:0] d, input string tag);
    int e;
    btn = b; addr = a; we = w; wdata = d;
    @(negedge clk);
    #1;
    e = expected(int'(addr));
    checks++;
    if (int'(rdata) != e) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, addr, rdata, e[7:0]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int a = 0; a < 4; a++) step(10'h000, a[1:0], 0, 8'h00, "R1");
    step(10'h3FF, 2'd0, 0, 8'h00, "R1");
    rst_n = 1;
    step(10'h000, 2'd1, 0, 8'h00, "R1");
    step(10'h000, 2'd0, 0, 8'h00, "R1");

    for (int n = 0; n < 8; n++) begin
      step(10'(1 << n), 2'd0, 0, 8'h00, "R2");
      step(10'(1 << n), 2'd0, 0, 8'h00, "R2");
      step(10'(1 << n), 2'd0, 0, 8'h00, "R2");
    end
    for (int n = 8; n < 10; n++) begin
      step(10'(1 << n), 2'd1, 0, 8'h00, "R3");
      step(10'(1 << n), 2'd1, 0, 8'h00, "R3");
      step(10'(1 << n), 2'd1, 0, 8'h00, "R3");
    end
    for (int k = 0; k < 4; k++) step(10'h300, 2'd1, 0, 8'h00, "R3");

    for (int k = 0; k < 3; k++) step(10'h0C0, 2'd0, 0, 8'h00, "R4");
    for (int k = 0; k < 3; k++) step(10'h0C5, 2'd0, 0, 8'h00, "R4");
    for (int k = 0; k < 3; k++) step(10'h080, 2'd0, 0, 8'h00, "R4");
    for (int k = 0; k < 3; k++) step(10'h030, 2'd0, 0, 8'h00, "R5");
    for (int k = 0; k < 3; k++) step(10'h13A, 2'd0, 0, 8'h00, "R5");
    for (int k = 0; k < 3; k++) step(10'h3FF, 2'd0, 0, 8'h00, "R5");
    for (int k = 0; k < 3; k++) step(10'h3FF, 2'd1, 0, 8'h00, "R5");

    step(10'h000, 2'd0, 0, 8'h00, "R9");
    step(10'h001, 2'd0, 0, 8'h00, "R9");
    step(10'h002, 2'd0, 0, 8'h00, "R9");
    step(10'h004, 2'd0, 0, 8'h00, "R9");
    step(10'h000, 2'd0, 0, 8'h00, "R9");
    step(10'h000, 2'd0, 0, 8'h00, "R9");

    step(10'h000, 2'd2, 1, 8'hA5, "R6");
    step(10'h000, 2'd2, 0, 8'h00, "R6");
    step(10'h000, 2'd3, 0, 8'h00, "R6");
    step(10'h000, 2'd3, 1, 8'h3C, "R7");
    step(10'h000, 2'd3, 0, 8'h00, "R7");
    step(10'h000, 2'd2, 0, 8'h00, "R7");
    step(10'h000, 2'd2, 1, 8'h5A, "R6");
    step(10'h000, 2'd3, 0, 8'h00, "R6");

    step(10'h041, 2'd0, 1, 8'hFF, "R8");
    step(10'h041, 2'd1, 1, 8'h00, "R8");
    step(10'h041, 2'd0, 1, 8'h00, "R8");
    step(10'h041, 2'd1, 0, 8'h00, "R8");
    step(10'h041, 2'd2, 0, 8'h00, "R8");
    step(10'h041, 2'd3, 0, 8'h00, "R8");

    rst_n = 0;
    step(10'h000, 2'd3, 0, 8'h00, "R1");
    step(10'h000, 2'd2, 0, 8'h00, "R1");
    rst_n = 1;
    step(10'h000, 2'd0, 0, 8'h00, "R1");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule